// File: doc/BRIEF.md
# Secure Scan Response Comparator

This block sits behind the scan-out pins of one or more sensitive scan chains. The tester does not unload the captured flip-flop values. It shifts in the response it expects, one bit per chain per shift cycle, alongside the next stimulus. Each chain has a sticky mismatch flag that records whether any compared bit differed. All chains share one down counter, which measures how many bits of the vector have been compared.

The block releases nothing about individual bits. In the first capture cycle after a shift of at least the chain length, the shared scan-in pad switches to output and carries one bit. That bit is high only if every compared bit of every chain matched. In every other cycle the pad stays an input, the result line is low, and the pad value passes through to the chains as scan-in data.

The block is parameterised by the number of chains and by the length of the longest chain.

Top module: `secure_scan_cmp`

## Requirements
- R1: Reset is synchronous and active low. After reset, the pad is an input (`pad_oe`=0, `pad_out`=0), including in a capture cycle that follows reset with no shift in between.
- R2: A result is presented only after at least CHAIN_LEN consecutive shift cycles (`scan_en`=1) since the last cycle with `scan_en` low. A capture that follows a shorter shift keeps `pad_oe`=0.
- R3: When every compared bit of every chain equals its expected bit, the first capture cycle shows `pad_oe`=1 and `pad_out`=1.
- R4: A single differing bit at any position of the compared window forces `pad_out`=0 in that capture cycle, with `pad_oe`=1.
- R5: A mismatch is sticky. A differing first bit still fails the vector even when every later bit matches.
- R6: Every cycle with `scan_en` low clears all mismatch flags, so a matching vector passes after a failed one.
- R7: Only the first CHAIN_LEN shift cycles of a vector are compared. The counter stops at zero, and mismatches in later shift cycles do not change the result.
- R8: The pad drives only in the first cycle of a capture, never while `scan_en` is high. From the second consecutive low cycle it is an input again.
- R9: `pad_out` is 0 whenever `pad_oe` is 0.
- R10: `scan_in_o` equals `pad_in` while the pad is an input, and is 0 while the pad drives.
- R11: The result is the AND over all chains. One failing chain fails the vector even if every other chain matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | High = shift, low = capture |
| chain_so | input | NUM_CHAINS | Actual scan-out bit of each chain |
| exp_bits | input | NUM_CHAINS | Expected bit for each chain, supplied by the tester |
| pad_in | input | 1 | Value seen on the shared scan-in/result pad |
| pad_out | output | 1 | Result driven onto the pad (1 = whole vector matched) |
| pad_oe | output | 1 | Pad output enable; high only while a valid result is shown |
| scan_in_o | output | 1 | Scan-in data forwarded to the chains |

## Verification
The bench builds the block with NUM_CHAINS=2 and CHAIN_LEN=8. With this short length, vectors cut short, exact-length vectors and vectors with shift cycles past the window can all be run within a few hundred cycles. It places mismatches at the first and last compared positions and past the window. Two chains are enough to show that one bad chain fails the vector when the other matched, and that a failed vector does not spill into the next one.

// File: rtl/ssrc_pkg.sv
// Package: shared helpers for the secure scan response comparator.
// Assumes: chain lengths are at least one.
package ssrc_pkg;

    // Width needed to hold a count from 0 up to len inclusive.
    function automatic int cnt_width(input int len);
        return (len < 1) ? 1 : $clog2(len + 1);
    endfunction

endpackage

// File: rtl/ssrc_len_counter.sv
// Module: ssrc_len_counter
// Shared bit counter. It reloads CHAIN_LEN whenever scan_en is low and
// counts down once per shift cycle, stopping at zero.
// Assumes: CHAIN_LEN >= 1; one counter serves every chain.
module ssrc_len_counter #(
    parameter int CHAIN_LEN = 64,
    parameter int CW        = ssrc_pkg::cnt_width(CHAIN_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    output logic term,     // all CHAIN_LEN bits have been compared
    output logic cmp_en    // current shift cycle belongs to the window
);

    localparam logic [CW-1:0] LOAD_VAL = CW'(CHAIN_LEN);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] remain_q;

    // Reload on reset or capture; otherwise count down, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= LOAD_VAL;
        end else if (!scan_en) begin
            remain_q <= LOAD_VAL;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - ONE;
        end
    end

    // Decode terminal count and the comparison window.
    always_comb begin
        term   = (remain_q == '0);
        cmp_en = scan_en && (remain_q != '0);
    end

endmodule

// File: rtl/ssrc_sticky_cmp.sv
// Module: ssrc_sticky_cmp
// Per-chain sticky comparator. Inside the window, a difference between
// the actual and expected bit sets the flag. The flag holds until a
// cycle with scan_en low.
// Assumes: cmp_en comes from the shared counter.
module ssrc_sticky_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic cmp_en,
    input  logic act_bit,
    input  logic exp_bit,
    output logic mis_flag
);

    logic diff;

    // Bitwise difference of actual and expected stream.
    always_comb begin
        diff = act_bit ^ exp_bit;
    end

    // Clear on reset or capture; accumulate differences inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en) begin
            mis_flag <= 1'b0;
        end else if (cmp_en && diff) begin
            mis_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/ssrc_pad_ctrl.sv
// Module: ssrc_pad_ctrl
// Gates each chain's pass bit with terminal count, ANDs the chains and
// runs the shared scan-in/result pad. The pad drives only in a capture
// cycle that follows a complete window.
// Assumes: flags and term are registered, so this logic has no state.
module ssrc_pad_ctrl #(
    parameter int NUM_CHAINS = 4
) (
    input  logic                  scan_en,
    input  logic                  term,
    input  logic [NUM_CHAINS-1:0] mis_flag,
    input  logic                  pad_in,
    output logic                  pad_oe,
    output logic                  pad_out,
    output logic                  scan_in_o
);

    logic [NUM_CHAINS-1:0] chain_pass;

    // Per-chain output gating: pass only at terminal count with a clean flag.
    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_gate
        always_comb begin
            chain_pass[c] = term && !mis_flag[c];
        end
    end

    // Pad direction, result value and scan-in forwarding.
    always_comb begin
        pad_oe    = !scan_en && term;
        pad_out   = pad_oe && (&chain_pass);
        scan_in_o = pad_in && !pad_oe;
    end

endmodule

// File: rtl/secure_scan_cmp.sv
// Module: secure_scan_cmp (top)
// On-chip comparison of scan responses against a tester-supplied
// expected stream. Only a single pass/fail bit per vector leaves the
// block, on the pad shared with scan-in.
// Assumes: every chain is CHAIN_LEN long or is padded to it by the tester.
module secure_scan_cmp #(
    parameter int NUM_CHAINS = 4,
    parameter int CHAIN_LEN  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_en,
    input  logic [NUM_CHAINS-1:0] chain_so,
    input  logic [NUM_CHAINS-1:0] exp_bits,
    input  logic                  pad_in,
    output logic                  pad_out,
    output logic                  pad_oe,
    output logic                  scan_in_o
);

    localparam int CW = ssrc_pkg::cnt_width(CHAIN_LEN);

    logic                  term;
    logic                  cmp_en;
    logic [NUM_CHAINS-1:0] mis_flag;

    ssrc_len_counter #(
        .CHAIN_LEN (CHAIN_LEN),
        .CW        (CW)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (scan_en),
        .term    (term),
        .cmp_en  (cmp_en)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        ssrc_sticky_cmp u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .scan_en  (scan_en),
            .cmp_en   (cmp_en),
            .act_bit  (chain_so[c]),
            .exp_bit  (exp_bits[c]),
            .mis_flag (mis_flag[c])
        );
    end

    ssrc_pad_ctrl #(
        .NUM_CHAINS (NUM_CHAINS)
    ) u_pad (
        .scan_en   (scan_en),
        .term      (term),
        .mis_flag  (mis_flag),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .scan_in_o (scan_in_o)
    );

endmodule

// File: rtl/ssrc_checker.sv
// Module: ssrc_checker
// Port-level properties of secure_scan_cmp. It keeps its own count of
// shift cycles since the last capture, independent of the design's counter.
// Assumes: bound to every instance of the top module.
module ssrc_checker #(
    parameter int CHAIN_LEN = 64
) (
    input logic clk,
    input logic rst_n,
    input logic scan_en,
    input logic pad_in,
    input logic pad_oe,
    input logic pad_out,
    input logic scan_in_o
);

    localparam int SW = ssrc_pkg::cnt_width(CHAIN_LEN);
    localparam logic [SW-1:0] FULL = SW'(CHAIN_LEN);

    logic [SW-1:0] shifts_q;

    // Count consecutive shift cycles, stopping at the chain length.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en) begin
            shifts_q <= '0;
        end else if (shifts_q != FULL) begin
            shifts_q <= shifts_q + SW'(1);
        end
    end

    a_r9_out_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        pad_out |-> pad_oe);

    a_r8_no_drive_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> !scan_en);

    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |=> !pad_oe);

    a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (shifts_q == FULL));

    a_r2_result_shown: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && shifts_q == FULL) |-> pad_oe);

    a_r10_no_loopback: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> !scan_in_o);

    a_r10_forward: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> (scan_in_o == pad_in));

endmodule

bind secure_scan_cmp ssrc_checker #(
    .CHAIN_LEN (CHAIN_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .scan_in_o (scan_in_o)
);

// File: tb/sim_secure_scan_cmp.sv
`timescale 1ns/1ps
module sim_secure_scan_cmp;

    localparam int NCH = 2;
    localparam int LEN = 8;
    localparam int XL  = LEN + 4;

    typedef struct {
        bit    oe;
        bit    out;
        string req;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scan_en = 1'b0;
    logic [NCH-1:0] chain_so = '0;
    logic [NCH-1:0] exp_bits = '0;
    logic           pad_in = 1'b0;
    logic           pad_out;
    logic           pad_oe;
    logic           scan_in_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];
    event  sample_ev;

    secure_scan_cmp #(.NUM_CHAINS(NCH), .CHAIN_LEN(LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chain_so(chain_so),
        .exp_bits(exp_bits), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .scan_in_o(scan_in_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Monitor: pops each expected item and compares it with the pad.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(pad_oe == it.oe, {it.req, " pad_oe"}, int'(pad_oe), int'(it.oe));
                check(pad_out == it.out, {it.req, " pad_out"}, int'(pad_out), int'(it.out));
            end
        end
    end

    // Driver: shifts nshift cycles, computes the expected result, then runs two capture cycles.
    task automatic run_vec(input logic [NCH-1:0][XL-1:0] resp,
                           input logic [NCH-1:0][XL-1:0] expv,
                           input int nshift, input string req);
        item_t it;
        bit pass = 1'b1;
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < LEN; k++)
                if (resp[c][k] != expv[c][k]) pass = 1'b0;
        for (int k = 0; k < nshift; k++) begin
            @(negedge clk);
            scan_en = 1'b1;
            pad_in  = k[0];
            for (int c = 0; c < NCH; c++) begin
                chain_so[c] = resp[c][k];
                exp_bits[c] = expv[c][k];
            end
            if (k == nshift - 1) begin
                #1;
                // R9: no drive while shifting; R10: pad forwarded as scan-in
                check(!pad_oe && !pad_out, "R9", int'(pad_out), 0);
                check(scan_in_o == pad_in, "R10", int'(scan_in_o), int'(pad_in));
            end
        end
        @(negedge clk);
        scan_en  = 1'b0;
        chain_so = '0;
        exp_bits = '0;
        pad_in   = 1'b1;
        #1;
        it.oe  = (nshift >= LEN);
        it.out = (nshift >= LEN) && pass;
        it.req = req;
        sb_q.push_back(it);
        -> sample_ev;
        #0;
        check(scan_in_o == !it.oe, "R10 capture", int'(scan_in_o), int'(!it.oe));
        @(negedge clk);
        #1;
        it.oe  = 1'b0;
        it.out = 1'b0;
        it.req = "R8 second capture";
        sb_q.push_back(it);
        -> sample_ev;
        #0;
    endtask

    // Stimulus.
    initial begin
        logic [NCH-1:0][XL-1:0] a, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!pad_oe && !pad_out, "R1 reset", int'(pad_oe), 0);

        a[0] = 12'hA5C; a[1] = 12'h3E7;
        e = a;
        run_vec(a, e, LEN, "R3 full match");

        e = a; e[1][LEN-1] = ~e[1][LEN-1];
        run_vec(a, e, LEN, "R4 last bit differs");

        e = a;
        run_vec(a, e, LEN, "R6 pass after fail");

        e = a; e[0][0] = ~e[0][0];
        run_vec(a, e, LEN, "R5 first bit sticky");

        e = a;
        run_vec(a, e, LEN - 1, "R2 short shift");

        e = a; e[0][LEN+1] = ~e[0][LEN+1]; e[1][LEN] = ~e[1][LEN];
        run_vec(a, e, LEN + 3, "R7 beyond window ignored");

        a[0] = 12'h0F0; a[1] = 12'h055;
        e = a; e[1] = ~a[1];
        run_vec(a, e, LEN, "R11 one chain bad");

        e = '0;
        run_vec(a, e, LEN, "R4 all-zero expected");

        a = '0; e = '0;
        run_vec(a, e, LEN, "R3 zero response");

        finished = 1'b1;
        report();
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            report();
            $finish;
        end
    end

endmodule